// File: doc/BRIEF.md
# BCD Real-Time Clock Register Window

This block keeps calendar time in binary-coded decimal and exposes it as eight byte registers at the top of an 11-bit byte address space. The counters for seconds, minutes, hours, weekday, day of month, month and two-digit year live inside the block. What software reads and writes are shadow cells. On every one-second tick the running counters advance, and on the following clock cycle the shadow cells take a fresh copy of them.

A control byte gives software two ways to stop that copy. A freeze flag holds the shadow cells steady while a multi-byte read is in progress, and the counters keep running underneath. A hold flag also stops the copy and lets software load new time values into the cells. Clearing the hold flag transfers all seven cells into the counters in one cycle. A stop flag in the seconds byte halts counting altogether. Access is a synchronous byte port with registered read data.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: The window decodes the eight addresses whose upper bits are all ones. Offset 0 is control, offset 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. Read data appears on the cycle after the request. A read outside the window returns 00h.
- R2: After reset the control byte reads 00h and the seconds byte reads 80h (stop set, 00 seconds). Minutes and hours read 00, weekday 01, day of month 01, month 01 and year 00.
- R3: While the stop bit (seconds bit 7) is 1, ticks do not change the counters.
- R4: With the stop bit clear, each tick adds one second. Seconds and minutes roll from 59 to 00 and hours roll from 23 to 00, and each rollover carries into the next field, all in BCD.
- R5: An hour rollover advances the weekday and the day of month together, and the weekday wraps from 07 to 01. The day of month wraps after 28, 29, 30 or 31 according to the month. February has 29 days when the year is a multiple of four, 00 included. Month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R6: When control bits 7 and 6 are both 0 at a tick, the cycle after the tick copies all seven counters into the shadow cells at once. That copy replaces anything software wrote into a time cell.
- R7: Writing 1 to control bit 6 (freeze) stops the copy while the counters keep running. After the bit is cleared, the next tick exposes the current time.
- R8: Writing 1 to control bit 7 (hold) stops the copy, so software can load the cells. A control write that clears bit 7 while it is set loads every cell into the counters in that cycle, and counting continues from the loaded time.
- R9: A copy decided at a tick completes even if freeze or hold is written in the cycle that follows.
- R10: Unused bits read 0. Control bits 5..0 read 0, and stored values are masked: minutes 7Fh, hours 3Fh, day of month 3Fh, month 1Fh.
- R11: The stop bit and the test flag (weekday bit 6) can be written without the hold bit, and copies leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s_i | input | 1 | One-cycle pulse once per second |
| acc_en_i | input | 1 | Access request |
| acc_we_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | ADDR_W | Byte address |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with the default 11-bit address width, so the window sits at 7F8h–7FFh and addresses below it exercise the outside-window read. The bench drives the one-second tick directly and loads times just before a boundary through the hold flag. Each carry case then takes one tick: minute and hour rollovers, short months, leap and common Februaries, year 00 and the century wrap. Directed sequences place control writes in the exact cycle after a tick to exercise the in-flight copy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    localparam int NFIELD = 7;

    typedef struct packed {
        logic [7:0] val;
        logic       wrap;
    } bcd_step_t;

    // Bits kept for each time field, index 0 = seconds .. 6 = year
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2, 4:    return 8'h3F;
            3:       return 8'h07;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic [3:0] u;
        u = y[3:0];
        if (!y[4]) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
        return (u == 4'd2) || (u == 4'd6);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // One BCD field step: wraps to lo at or beyond hi, else adds one
    function automatic bcd_step_t bcd_step(input logic [7:0] cur, input logic [7:0] hi,
                                           input logic [7:0] lo, input logic en);
        bcd_step_t r;
        r.val  = cur;
        r.wrap = 1'b0;
        if (en) begin
            if (cur >= hi) begin
                r.val  = lo;
                r.wrap = 1'b1;
            end else if (cur[3:0] >= 4'd9) begin
                r.val = {cur[7:4] + 4'd1, 4'd0};
            end else begin
                r.val = {cur[7:4], cur[3:0] + 4'd1};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t cnt_o
);

    rtc_time_t cnt_d, cnt_q;

    always_comb begin
        bcd_step_t s_sec, s_min, s_hr, s_wd, s_md, s_mo, s_yr;
        logic [7:0] dim;
        dim   = month_days(cnt_q.month, cnt_q.year);
        s_sec = bcd_step(cnt_q.secs,  8'h59, 8'h00, adv_i);
        s_min = bcd_step(cnt_q.mins,  8'h59, 8'h00, s_sec.wrap);
        s_hr  = bcd_step(cnt_q.hours, 8'h23, 8'h00, s_min.wrap);
        s_wd  = bcd_step(cnt_q.wday,  8'h07, 8'h01, s_hr.wrap);
        s_md  = bcd_step(cnt_q.mday,  dim,   8'h01, s_hr.wrap);
        s_mo  = bcd_step(cnt_q.month, 8'h12, 8'h01, s_md.wrap);
        s_yr  = bcd_step(cnt_q.year,  8'h99, 8'h00, s_mo.wrap);
        cnt_d.secs  = s_sec.val;
        cnt_d.mins  = s_min.val;
        cnt_d.hours = s_hr.val;
        cnt_d.wday  = s_wd.val;
        cnt_d.mday  = s_md.val;
        cnt_d.month = s_mo.val;
        cnt_d.year  = s_yr.val;
        if (load_i) cnt_d = load_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '{year: 8'h00, month: 8'h01, mday: 8'h01, wday: 8'h01,
                       hours: 8'h00, mins: 8'h00, secs: 8'h00};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    // R4: an advancing tick always changes the count
    assert_tick_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/rtc_user_file.sv
module rtc_user_file
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              acc_en_i,
    input  logic              acc_we_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [7:0]        acc_wdata_i,
    input  rtc_time_t         cnt_i,
    output rtc_time_t         cells_o,
    output logic              stop_o,
    output logic              load_o
);

    localparam int OFF_W = 3;

    typedef struct packed {
        rtc_time_t  cells;
        logic       stop;
        logic       ftest;
        logic       hold_w;
        logic       freeze_r;
        logic       copy_pend;
        logic [7:0] rdata;
    } ufile_t;

    ufile_t st_d, st_q;

    logic              in_win;
    logic [OFF_W-1:0]  off;
    logic              wr_hit;
    logic              rd_req;
    logic              time_wr;

    assign in_win  = &acc_addr_i[ADDR_W-1:OFF_W];
    assign off     = acc_addr_i[OFF_W-1:0];
    assign wr_hit  = acc_en_i && acc_we_i && in_win;
    assign rd_req  = acc_en_i && !acc_we_i;
    assign time_wr = wr_hit && (off != '0);

    always_comb begin
        logic [8*NFIELD-1:0] cv;
        logic [8*NFIELD-1:0] cq;
        int idx;
        st_d   = st_q;
        cv     = st_q.cells;
        cq     = st_q.cells;
        idx    = int'(off) - 1;
        load_o = wr_hit && (off == '0) && st_q.hold_w && !acc_wdata_i[7];

        st_d.copy_pend = tick_i && !st_q.hold_w && !st_q.freeze_r;

        if (wr_hit) begin
            if (off == '0) begin
                st_d.hold_w   = acc_wdata_i[7];
                st_d.freeze_r = acc_wdata_i[6];
            end else begin
                cv[8*idx +: 8] = acc_wdata_i & field_mask(idx);
                if (off == 3'd1) st_d.stop  = acc_wdata_i[7];
                if (off == 3'd4) st_d.ftest = acc_wdata_i[6];
            end
        end
        st_d.cells = cv;

        if (st_q.copy_pend) st_d.cells = cnt_i;

        if (rd_req) begin
            if (!in_win) begin
                st_d.rdata = 8'h00;
            end else begin
                case (off)
                    3'd0:    st_d.rdata = {st_q.hold_w, st_q.freeze_r, 6'b0};
                    3'd1:    st_d.rdata = {st_q.stop, st_q.cells.secs[6:0]};
                    3'd4:    st_d.rdata = {1'b0, st_q.ftest, 3'b0, st_q.cells.wday[2:0]};
                    default: st_d.rdata = cq[8*idx +: 8];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cells: '{year: 8'h00, month: 8'h01, mday: 8'h01, wday: 8'h01,
                               hours: 8'h00, mins: 8'h00, secs: 8'h00},
                      stop: 1'b1, ftest: 1'b0, hold_w: 1'b0, freeze_r: 1'b0,
                      copy_pend: 1'b0, rdata: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    assign cells_o = st_q.cells;
    assign stop_o  = st_q.stop;

    // R6: a pending copy takes all seven counters in one cycle
    assert_copy_all_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.copy_pend |=> (st_q.cells == $past(cnt_i)));

    // R7: frozen cells stay put unless software writes them
    assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.freeze_r && !st_q.copy_pend && !time_wr) |=> $stable(st_q.cells));

    // R11: copies never disturb the stop and test flags
    assert_flags_survive_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.copy_pend && !time_wr) |=> ($stable(st_q.stop) && $stable(st_q.ftest)));

    // R1: registered read data for the port
    logic [7:0] rdata_unused;
    assign rdata_unused = st_q.rdata;

endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s_i,
    input  logic              acc_en_i,
    input  logic              acc_we_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [7:0]        acc_wdata_i,
    output logic [7:0]        acc_rdata_o
);

    rtc_time_t cnt;
    rtc_time_t cells;
    logic      stop;
    logic      load;
    logic      adv;

    assign adv = tick_1s_i && !stop;

    rtc_time_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (load),
        .load_val_i (cells),
        .cnt_o      (cnt)
    );

    rtc_user_file #(.ADDR_W(ADDR_W)) u_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_1s_i),
        .acc_en_i    (acc_en_i),
        .acc_we_i    (acc_we_i),
        .acc_addr_i  (acc_addr_i),
        .acc_wdata_i (acc_wdata_i),
        .cnt_i       (cnt),
        .cells_o     (cells),
        .stop_o      (stop),
        .load_o      (load)
    );

    assign acc_rdata_o = u_file.rdata_unused;

    logic in_win;
    assign in_win = &acc_addr_i[ADDR_W-1:3];

    // R3: stopped counters do not move
    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> $stable(cnt));

    // R8: releasing hold transfers every cell into the counters
    assert_load_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(cells)));

    // R1: reads outside the window return zero
    assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_we_i && !in_win) |=> (acc_rdata_o == 8'h00));

    // R10: unused control bits read as zero
    assert_ctrl_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_we_i && in_win && acc_addr_i[2:0] == 3'd0) |=> (acc_rdata_o[5:0] == 6'd0));

endmodule

// File: tb/bcd_rtc_regfile_tb.sv
module bcd_rtc_regfile_tb;

    localparam logic [10:0] BASE = 11'h7F8;
    localparam int NVEC = 11;
    // {expected after one tick, loaded start}; bytes year,month,mday,wday,hours,mins,secs
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h00_01_01_01_00_00_01, 56'h00_01_01_01_00_00_00},
        {56'h00_01_01_01_12_35_00, 56'h00_01_01_01_12_34_59},
        {56'h00_01_01_01_00_00_00, 56'h99_12_31_07_23_59_59},
        {56'h23_03_01_04_00_00_00, 56'h23_02_28_03_23_59_59},
        {56'h24_02_29_04_00_00_00, 56'h24_02_28_03_23_59_59},
        {56'h24_03_01_05_00_00_00, 56'h24_02_29_04_23_59_59},
        {56'h05_05_01_07_00_00_00, 56'h05_04_30_06_23_59_59},
        {56'h05_02_01_01_00_00_00, 56'h05_01_31_07_23_59_59},
        {56'h05_06_15_02_10_00_00, 56'h05_06_15_02_09_59_59},
        {56'h00_02_29_02_00_00_00, 56'h00_02_28_01_23_59_59},
        {56'h13_12_01_06_00_00_00, 56'h13_11_30_05_23_59_59}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [7:0]  got;

    always #5 clk = ~clk;

    bcd_rtc_regfile #(.ADDR_W(11)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1s_i   (tick),
        .acc_en_i    (en),
        .acc_we_i    (we),
        .acc_addr_i  (addr),
        .acc_wdata_i (wdata),
        .acc_rdata_o (rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 en = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        #1 en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic tick_copy();
        pulse();
        @(posedge clk);
        #1;
    endtask

    task automatic load_time(input logic [55:0] t);
        wr(BASE, 8'h80);
        for (int i = 0; i < 7; i++) wr(BASE + 11'(i + 1), t[8*i +: 8]);
        wr(BASE, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();

        // Reset image (R2) and window decode (R1)
        rd(BASE, got);          check("R2 control", got, 8'h00);
        rd(BASE + 11'd1, got);  check("R2 seconds", got, 8'h80);
        rd(BASE + 11'd2, got);  check("R2 minutes", got, 8'h00);
        rd(BASE + 11'd3, got);  check("R2 hours", got, 8'h00);
        rd(BASE + 11'd4, got);  check("R2 weekday", got, 8'h01);
        rd(BASE + 11'd5, got);  check("R2 mday", got, 8'h01);
        rd(BASE + 11'd6, got);  check("R2 month", got, 8'h01);
        rd(BASE + 11'd7, got);  check("R2 year", got, 8'h00);
        rd(11'h000, got);       check("R1 outside low", got, 8'h00);
        rd(11'h7F7, got);       check("R1 below window", got, 8'h00);

        // R3: stopped after reset, ticks ignored
        tick_copy(); tick_copy(); tick_copy();
        rd(BASE + 11'd1, got);  check("R3 stopped seconds", got, 8'h80);

        // R11: stop and test flag written without hold
        wr(BASE + 11'd1, 8'h00);
        tick_copy();
        rd(BASE + 11'd1, got);  check("R11 stop cleared counts", got, 8'h01);
        wr(BASE + 11'd4, 8'h41);
        tick_copy();
        rd(BASE + 11'd4, got);  check("R11 test flag kept", got, 8'h41);
        rd(BASE + 11'd1, got);  check("R11 seconds", got, 8'h02);

        // R6: direct write is replaced by the next copy
        wr(BASE + 11'd2, 8'h33);
        rd(BASE + 11'd2, got);  check("R6 written cell", got, 8'h33);
        tick_copy();
        rd(BASE + 11'd2, got);  check("R6 copy overwrites", got, 8'h00);
        rd(BASE + 11'd1, got);  check("R6 seconds", got, 8'h03);

        // R10: masking of unused bits
        wr(BASE + 11'd3, 8'hFF);
        rd(BASE + 11'd3, got);  check("R10 hours mask", got, 8'h3F);
        wr(BASE + 11'd6, 8'hFF);
        rd(BASE + 11'd6, got);  check("R10 month mask", got, 8'h1F);
        wr(BASE, 8'h3F);
        rd(BASE, got);          check("R10 control low bits", got, 8'h00);
        tick_copy();
        rd(BASE + 11'd3, got);  check("R6 hours restored", got, 8'h00);

        // R4 R5: carry table
        for (int v = 0; v < NVEC; v++) begin
            load_time(VEC[v][55:0]);
            tick_copy();
            for (int i = 0; i < 7; i++) begin
                rd(BASE + 11'(i + 1), got);
                check($sformatf("R4 R5 vector %0d field %0d", v, i), got, VEC[v][56 + 8*i +: 8]);
            end
        end

        // R7: freeze holds cells while counters run
        load_time(56'h05_06_15_02_10_20_30);
        wr(BASE, 8'h40);
        tick_copy(); tick_copy();
        rd(BASE + 11'd1, got);  check("R7 frozen seconds", got, 8'h30);
        rd(BASE, got);          check("R7 control reads freeze", got, 8'h40);
        wr(BASE, 8'h00);
        tick_copy();
        rd(BASE + 11'd1, got);  check("R7 counters kept running", got, 8'h33);

        // R9: copy decided at a tick survives a freeze written next cycle
        load_time(56'h05_06_15_02_10_20_30);
        pulse();
        wr(BASE, 8'h40);
        rd(BASE + 11'd1, got);  check("R9 in-flight copy", got, 8'h31);
        tick_copy();
        rd(BASE + 11'd1, got);  check("R9 freeze after copy", got, 8'h31);
        wr(BASE, 8'h00);

        // R8: hold, load, release
        wr(BASE, 8'h80);
        wr(BASE + 11'd1, 8'h45);
        wr(BASE + 11'd2, 8'h07);
        tick_copy(); tick_copy();
        rd(BASE + 11'd1, got);  check("R8 held seconds", got, 8'h45);
        wr(BASE, 8'h00);
        tick_copy();
        rd(BASE + 11'd1, got);  check("R8 loaded seconds advance", got, 8'h46);
        rd(BASE + 11'd2, got);  check("R8 loaded minutes", got, 8'h07);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule